// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers completion and error events from a bank of DMA channels and presents them to a processor through a small register bus. Each channel reports four kinds of event: the whole transfer chain finished, a flagged node of the chain finished, an error of the first class, and an error of the second class. An event arrives as a one-cycle pulse that carries a kind code and a channel index. The block latches it in a per-kind raw register, in the bit position that belongs to that channel.

Software picks the sources it wants through one enable-mask register per kind. It reads the enabled events through a masked status view per kind, or through one summary register that ORs the four masked views per channel. A single level-sensitive interrupt line stays high while any enabled event is pending. Software acknowledges an event by writing a one to its bit in the raw register. The bus has a write port and a read port with combinational read data.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every raw and mask register reads zero, the summary reads zero and `irq` is low.
- R2: A pulse on `evt_vld` with kind code `evt_kind` (0 chain done, 1 node done, 2 error class 1, 3 error class 2) sets bit `evt_ch` of that kind's raw register. The bit is readable on the cycle after the pulse, whatever the mask holds.
- R3: A write to a mask register (kind k at 0x018 + 4k) stores `wr_data[NCH-1:0]`. The value reads back unchanged. With no mask write the register does not change.
- R4: The masked status of kind k (at 0x004 + 4k) reads as raw AND mask of that kind.
- R5: A write to a raw register (kind k at 0x600 + 8k) clears every bit where `wr_data` holds a one and leaves the bits that are zero untouched. A raw bit falls only through such a write.
- R6: The summary register (at 0x000) holds bit c set when any of the four masked status registers has bit c set.
- R7: `irq` is high exactly while the summary is nonzero, and it stays high across idle cycles until the pending enabled bits are cleared.
- R8: When an event and a clear write hit the same raw bit in the same cycle, the bit ends set. The other bits in the clear write are still cleared.
- R9: With all four masks at zero, `irq` stays low and the summary reads zero, while the raw registers keep their events.
- R10: Bits above `NCH` in every register read zero. A read of an address outside the map returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_vld | input | 1 | One-cycle event pulse |
| evt_kind | input | 2 | Event kind code |
| evt_ch | input | CH_W | Channel that raised the event |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 12 | Read byte address |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| irq | output | 1 | Level interrupt |

## Verification
Events and writes take effect at the clock edge that samples them. Their results can be read one cycle later: the raw bit, the masked status, the summary and `irq` all settle together after that single register stage. The bench drives every stimulus on a falling edge. It then issues a read on a later falling edge, while no event or write is active, and the monitor compares `rd_data` and `irq` two time units after the following rising edge. Each sample therefore sees state that is already stable.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int KINDS  = 4;
  localparam int ADDR_W = 12;
  localparam int REG_DW = 32;

  typedef enum logic [1:0] {
    K_CHAIN = 2'd0,
    K_NODE  = 2'd1,
    K_ERRA  = 2'd2,
    K_ERRB  = 2'd3
  } evt_kind_e;

  localparam logic [ADDR_W-1:0] A_SUMMARY = 12'h000;
  localparam logic [ADDR_W-1:0] A_STAT0   = 12'h004;
  localparam logic [ADDR_W-1:0] A_MASK0   = 12'h018;
  localparam logic [ADDR_W-1:0] A_RAW0    = 12'h600;

  function automatic logic [ADDR_W-1:0] stat_addr(input int k);
    return A_STAT0 + ADDR_W'(4 * k);
  endfunction

  function automatic logic [ADDR_W-1:0] mask_addr(input int k);
    return A_MASK0 + ADDR_W'(4 * k);
  endfunction

  function automatic logic [ADDR_W-1:0] raw_addr(input int k);
    return A_RAW0 + ADDR_W'(8 * k);
  endfunction

  function automatic logic [REG_DW-1:0] chan_bit(input logic [4:0] ch);
    return REG_DW'(1) << ch;
  endfunction

  // next raw value: clear by ones, then new events override
  function automatic logic [REG_DW-1:0] w1c_merge(input logic [REG_DW-1:0] cur,
                                                  input logic [REG_DW-1:0] set,
                                                  input logic [REG_DW-1:0] clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/irq_kind_bank.sv
module irq_kind_bank
  import irq_agg_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_vec,
  input  logic           clr_we,
  input  logic           mask_we,
  input  logic [NCH-1:0] wdata,
  output logic [NCH-1:0] raw_q,
  output logic [NCH-1:0] mask_q
);
  logic [REG_DW-1:0] raw_nx;
  logic [NCH-1:0]    clr_vec;

  assign clr_vec = clr_we ? wdata : '0;
  assign raw_nx  = w1c_merge(REG_DW'(raw_q), REG_DW'(set_vec), REG_DW'(clr_vec));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= raw_nx[NCH-1:0];
      if (mask_we) mask_q <= wdata;
    end
  end
endmodule

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_agg_pkg::*;
(
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [KINDS-1:0]  mask_we,
  output logic [KINDS-1:0]  clr_we,
  output logic              rd_sum,
  output logic [KINDS-1:0]  rd_stat,
  output logic [KINDS-1:0]  rd_mask,
  output logic [KINDS-1:0]  rd_raw
);
  assign rd_sum = (rd_addr == A_SUMMARY);

  for (genvar k = 0; k < KINDS; k++) begin : g_kind
    assign mask_we[k] = wr_en && (wr_addr == mask_addr(k));
    assign clr_we[k]  = wr_en && (wr_addr == raw_addr(k));
    assign rd_stat[k] = (rd_addr == stat_addr(k));
    assign rd_mask[k] = (rd_addr == mask_addr(k));
    assign rd_raw[k]  = (rd_addr == raw_addr(k));
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NCH = 16,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_vld,
  input  logic [1:0]        evt_kind,
  input  logic [CH_W-1:0]   evt_ch,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_DW-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_DW-1:0] rd_data,
  output logic              irq
);
  logic [KINDS-1:0]  mask_we, clr_we, rd_stat, rd_mask, rd_raw;
  logic              rd_sum;
  logic [NCH-1:0]    raw_q  [KINDS];
  logic [NCH-1:0]    mask_q [KINDS];
  logic [NCH-1:0]    pend   [KINDS];
  logic [NCH-1:0]    set_vec[KINDS];
  logic [NCH-1:0]    summary;
  logic [REG_DW-1:0] ev_onehot;
  logic [KINDS*NCH-1:0] raw_flat, mask_flat;

  assign ev_onehot = chan_bit(5'(evt_ch));

  irq_addr_decode u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .mask_we(mask_we), .clr_we(clr_we), .rd_sum(rd_sum),
    .rd_stat(rd_stat), .rd_mask(rd_mask), .rd_raw(rd_raw)
  );

  for (genvar k = 0; k < KINDS; k++) begin : g_bank
    assign set_vec[k] = (evt_vld && evt_kind == 2'(k)) ? ev_onehot[NCH-1:0] : '0;

    irq_kind_bank #(.NCH(NCH)) u_bank (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec[k]),
      .clr_we(clr_we[k]), .mask_we(mask_we[k]), .wdata(wr_data[NCH-1:0]),
      .raw_q(raw_q[k]), .mask_q(mask_q[k])
    );

    assign pend[k] = raw_q[k] & mask_q[k];
    assign raw_flat [k*NCH +: NCH] = raw_q[k];
    assign mask_flat[k*NCH +: NCH] = mask_q[k];
  end

  always_comb begin
    summary = '0;
    for (int k = 0; k < KINDS; k++) summary |= pend[k];
  end

  assign irq = |summary;

  always_comb begin
    rd_data = '0;
    if (rd_sum) rd_data = REG_DW'(summary);
    for (int k = 0; k < KINDS; k++) begin
      if (rd_stat[k]) rd_data = REG_DW'(pend[k]);
      if (rd_mask[k]) rd_data = REG_DW'(mask_q[k]);
      if (rd_raw[k])  rd_data = REG_DW'(raw_q[k]);
    end
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_agg_pkg::*;
#(
  parameter int NCH = 16,
  localparam int CH_W = $clog2(NCH)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 evt_vld,
  input logic [1:0]           evt_kind,
  input logic [CH_W-1:0]      evt_ch,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    wr_addr,
  input logic                 irq,
  input logic [KINDS*NCH-1:0] raw_flat,
  input logic [KINDS*NCH-1:0] mask_flat
);
  logic raw_hit, mask_hit;
  assign raw_hit  = wr_en && (wr_addr[11:5] == 7'h30) && (wr_addr[2:0] == 3'd0);
  assign mask_hit = wr_en && (wr_addr == 12'h018 || wr_addr == 12'h01C ||
                              wr_addr == 12'h020 || wr_addr == 12'h024);

  AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vld |=> raw_flat[{$past(evt_kind), $past(evt_ch)}]); // R2

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_vld |=> ((raw_flat & ~$past(raw_flat)) == '0)); // R2

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_hit |=> $stable(mask_flat)); // R3

  AST_CLEAR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_hit |=> ((~raw_flat & $past(raw_flat)) == '0)); // R5

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((raw_flat & mask_flat) != '0)); // R7

  AST_SILENT_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_flat == '0) |-> !irq); // R9
endmodule

bind irq_aggregator irq_aggregator_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_vld = 1'b0;
  logic [1:0]  evt_kind = '0;
  logic [3:0]  evt_ch = '0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [11:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  logic rd_act = 1'b0;
  logic done = 1'b0;

  logic [15:0] m_raw [4];
  logic [15:0] m_mask[4];

  logic [31:0] q_d[$];
  logic        q_i[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  irq_aggregator u0 (.*);

  function automatic logic [15:0] m_sum();
    logic [15:0] s = '0;
    for (int k = 0; k < 4; k++) s |= m_raw[k] & m_mask[k];
    return s;
  endfunction

  function automatic logic [31:0] m_reg(input logic [11:0] a);
    case (a)
      12'h000: return {16'h0, m_sum()};
      12'h004: return {16'h0, m_raw[0] & m_mask[0]};
      12'h008: return {16'h0, m_raw[1] & m_mask[1]};
      12'h00C: return {16'h0, m_raw[2] & m_mask[2]};
      12'h010: return {16'h0, m_raw[3] & m_mask[3]};
      12'h018: return {16'h0, m_mask[0]};
      12'h01C: return {16'h0, m_mask[1]};
      12'h020: return {16'h0, m_mask[2]};
      12'h024: return {16'h0, m_mask[3]};
      12'h600: return {16'h0, m_raw[0]};
      12'h608: return {16'h0, m_raw[1]};
      12'h610: return {16'h0, m_raw[2]};
      12'h618: return {16'h0, m_raw[3]};
      default: return 32'h0;
    endcase
  endfunction

  // driver: queue the expectation, hold the address for one edge
  task automatic rd(input logic [11:0] a, input string tag);
    @(negedge clk);
    rd_addr = a;
    rd_act = 1'b1;
    q_d.push_back(m_reg(a));
    q_i.push_back(m_sum() != 16'h0);
    q_tag.push_back(tag);
    @(negedge clk);
    rd_act = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a >= 12'h018 && a <= 12'h024 && a[1:0] == 2'b00) m_mask[(a - 12'h018) >> 2] = d[15:0];
    if (a >= 12'h600 && a <= 12'h618 && a[2:0] == 3'b000) m_raw[(a - 12'h600) >> 3] &= ~d[15:0];
  endtask

  task automatic ev(input int k, input int c);
    @(negedge clk);
    evt_vld = 1'b1; evt_kind = 2'(k); evt_ch = 4'(c);
    @(negedge clk);
    evt_vld = 1'b0;
    m_raw[k][c] = 1'b1;
  endtask

  // monitor: compare after the edge that follows the read set-up
  always @(posedge clk) begin
    #2;
    if (rd_act && q_d.size() > 0) begin
      logic [31:0] ed;
      logic        ei;
      string       t;
      ed = q_d.pop_front();
      ei = q_i.pop_front();
      t  = q_tag.pop_front();
      n_chk += 2;
      if (rd_data !== ed) begin
        n_bad++;
        $display("FAIL %s data addr=%h got=%h exp=%h", t, rd_addr, rd_data, ed);
      end
      if (irq !== ei) begin
        n_bad++;
        $display("FAIL R7 irq during %s got=%b exp=%b", t, irq, ei);
      end
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin m_raw[k] = '0; m_mask[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values of the whole map
    foreach (m_raw[k]) begin
      rd(12'h600 + 12'(8 * k), "R1 raw");
      rd(12'h018 + 12'(4 * k), "R1 mask");
    end
    rd(12'h000, "R1 summary");

    // R3 / R10: mask store with upper bits discarded
    wr(12'h018, 32'hABCD_FFFF);
    rd(12'h018, "R3 R10 mask0");
    wr(12'h01C, 32'h0000_00FF);
    wr(12'h020, 32'h0000_F0F0);
    wr(12'h024, 32'h0000_000F);
    rd(12'h01C, "R3 mask1");
    rd(12'h020, "R3 mask2");
    rd(12'h024, "R3 mask3");

    // R2: events of each kind on varied channels
    ev(0, 3);
    ev(1, 12);
    ev(2, 5);
    ev(3, 0);
    ev(3, 15);
    rd(12'h600, "R2 raw0");
    rd(12'h608, "R2 raw1 unmasked bit kept");
    rd(12'h610, "R2 raw2");
    rd(12'h618, "R2 raw3");

    // R4 / R6: masked views and the summary
    rd(12'h004, "R4 stat0");
    rd(12'h008, "R4 stat1");
    rd(12'h00C, "R4 stat2");
    rd(12'h010, "R4 stat3");
    rd(12'h000, "R6 summary");

    // R5: zero write keeps, one write clears
    wr(12'h618, 32'h0);
    rd(12'h618, "R5 zero write");
    wr(12'h618, 32'h0000_8000);
    rd(12'h618, "R5 clear ch15");
    rd(12'h000, "R6 summary after clear");

    // R8: event and clear collide on channel 7
    ev(0, 7);
    @(negedge clk);
    evt_vld = 1'b1; evt_kind = 2'd0; evt_ch = 4'd7;
    wr_en = 1'b1; wr_addr = 12'h600; wr_data = 32'h0000_0088;
    @(negedge clk);
    evt_vld = 1'b0; wr_en = 1'b0;
    m_raw[0] = (m_raw[0] & ~16'h0088) | 16'h0080;
    rd(12'h600, "R8 event wins");

    // R7: level held over idle cycles
    repeat (5) @(negedge clk);
    rd(12'h000, "R7 held");

    // R9: all masks zero silence the line, raw kept
    for (int k = 0; k < 4; k++) wr(12'h018 + 12'(4 * k), 32'h0);
    rd(12'h000, "R9 summary");
    rd(12'h610, "R9 raw kept");

    // R7: re-enable, then clear everything, the line drops
    wr(12'h018, 32'h0000_FFFF);
    rd(12'h004, "R7 re-enabled");
    for (int k = 0; k < 4; k++) wr(12'h600 + 12'(8 * k), 32'h0000_FFFF);
    rd(12'h000, "R7 cleared");

    // R10: holes in the map
    rd(12'h014, "R10 hole 0x014");
    rd(12'h604, "R10 hole 0x604");
    rd(12'h7FC, "R10 hole 0x7FC");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule